// File: doc/BRIEF.md
# Time-Slotted Serial Output Formatter

This block turns a set of parallel sample words into a single serial bit stream. A one-cycle strobe captures seven 24-bit source words: two I/Q pairs, magnitude, phase and gain. On the same edge it captures the frame configuration. After a programmable start delay, the block sends a frame of seven time slots in fixed order, one bit per clock. For each slot, a content code picks the source and a length code picks how many bits it takes, or disables it.

An optional sync output marks the slots that have their sync flag set. A shared placement code puts each pulse one clock before the slot's first bit, on the first bit, or one clock after the last bit. A separate polarity bit sets the sync's active level. Between frames the data line rests at zero and the sync line rests at its inactive level.

Top module: `slot_serializer`

## Requirements
- R1: After reset, `sdata` is 0 and `sync` is 0.
- R2: Within a frame, slots are sent in index order 0 to 6, with no gap between them.
- R3: Content codes select the source word: 0 I1, 1 Q1, 2 I2, 3 Q2, 4 magnitude, 5 phase, 6 gain, 7 all zeros. Source k sits in `src_words[24k+23:24k]`.
- R4: Length codes give the slot width: 1→4, 2→6, 3→8, 4→10, 5→12, 6→16, 7→20, 8→24, 9→32 bits. Codes 0 and 10–15 disable the slot.
- R5: A 32-bit slot sends the 24-bit word followed by 8 zero bits.
- R6: A disabled slot sends one zero bit when some later slot in the frame is enabled. Otherwise it takes no time.
- R7: Bits go out MSB first. A slot shorter than 24 bits sends the top bits of the word.
- R8: If the strobe is sampled at edge n, the first frame bit is on `sdata` after edge n+D+3, where D is `start_delay` (0..4095).
- R9: `sync_place` selects the sync position for each flagged slot: 0 = one clock before its first bit, 1 = on its first bit, 2 = one clock after its last bit, 3 = no sync. Disabled slots never get a sync.
- R10: `sync` equals the pulse XOR `sync_invert`. The polarity captured at the strobe applies from the strobe edge onward.
- R11: Outside frame bits, `sdata` is 0. Outside sync pulses, `sync` sits at its inactive level.
- R12: A strobe that arrives while a frame is still in delay or transmission is ignored.
- R13: Words and configuration are captured only on an accepted strobe. Changes made mid-frame do not alter the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe | input | 1 | Capture pulse that starts a frame |
| src_words | input | 168 | Seven 24-bit source words, source k at bits 24k+23:24k |
| slot_content | input | 21 | Content code per slot, slot s at bits 3s+2:3s |
| slot_length | input | 28 | Length code per slot, slot s at bits 4s+3:4s |
| slot_sync_en | input | 7 | Sync flag per slot |
| sync_place | input | 2 | Sync position code |
| sync_invert | input | 1 | Sync polarity, 1 = active low |
| start_delay | input | 12 | Clocks between the strobe and frame start |
| sdata | output | 1 | Serial data, MSB first |
| sync | output | 1 | Sync marker |

## Verification
A wrong slot index or bit counter in the sequencer shows up on `sdata` two clocks after it arises. From then on it shifts or truncates the rest of the frame, so a bit-by-bit comparison against a stream built arithmetically from the configuration finds it within that frame. A wrong collapse rule for disabled slots moves every later bit by one position. A wrong sync stage moves the marker by one clock relative to the data. A latch that is not held through the frame lets a mid-frame strobe or configuration change alter bits that are still to come. The sweeps cover every length code, every content code, random disable patterns, every sync placement under both polarities, and the delay extremes.

// File: rtl/ssf_pkg.sv
package ssf_pkg;
  localparam int LEN_CODE_W = 4;
  localparam int SPAN_W     = 6;
  localparam int PLACE_W    = 2;

  localparam logic [PLACE_W-1:0] PLACE_BEFORE = 2'd0;
  localparam logic [PLACE_W-1:0] PLACE_ALIGN  = 2'd1;
  localparam logic [PLACE_W-1:0] PLACE_AFTER  = 2'd2;

  typedef enum logic [1:0] {SQ_IDLE, SQ_WAIT, SQ_RUN} seq_state_t;

  // Bits carried by a slot for a given length code; 0 means disabled.
  function automatic logic [SPAN_W-1:0] len_bits(input logic [LEN_CODE_W-1:0] code);
    case (code)
      4'd1:    len_bits = 6'd4;
      4'd2:    len_bits = 6'd6;
      4'd3:    len_bits = 6'd8;
      4'd4:    len_bits = 6'd10;
      4'd5:    len_bits = 6'd12;
      4'd6:    len_bits = 6'd16;
      4'd7:    len_bits = 6'd20;
      4'd8:    len_bits = 6'd24;
      4'd9:    len_bits = 6'd32;
      default: len_bits = 6'd0;
    endcase
  endfunction
endpackage

// File: rtl/ssf_slot_plan.sv
module ssf_slot_plan
  import ssf_pkg::*;
#(
  parameter int NSLOT = 7
) (
  input  logic [NSLOT*LEN_CODE_W-1:0] len_codes,
  output logic [NSLOT*SPAN_W-1:0]     spans,
  output logic [NSLOT-1:0]            active
);
  logic [NSLOT-1:0] has_later;

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    assign active[k] = len_bits(len_codes[k*LEN_CODE_W +: LEN_CODE_W]) != '0;
    if (k == NSLOT - 1) begin : g_last
      assign has_later[k] = 1'b0;
    end else begin : g_mid
      assign has_later[k] = |active[NSLOT-1:k+1];
    end
    // Enabled slot: its length; disabled slot: one filler cell only if followed.
    assign spans[k*SPAN_W +: SPAN_W] =
      active[k]    ? len_bits(len_codes[k*LEN_CODE_W +: LEN_CODE_W]) :
      has_later[k] ? SPAN_W'(1) : '0;
  end
endmodule

// File: rtl/ssf_frame_seq.sv
module ssf_frame_seq
  import ssf_pkg::*;
#(
  parameter  int NSLOT   = 7,
  parameter  int DELAY_W = 12,
  localparam int SLOT_W  = $clog2(NSLOT)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    strobe,
  input  logic [DELAY_W-1:0]      delay_in,
  input  logic [NSLOT*SPAN_W-1:0] spans,
  output logic                    load,
  output logic                    busy,
  output logic                    cell_valid,
  output logic [SLOT_W-1:0]       slot_idx,
  output logic [SPAN_W-1:0]       bit_pos
);
  seq_state_t          state_q;
  logic [DELAY_W-1:0]  dly_q;
  logic [SLOT_W-1:0]   slot_q;
  logic [SPAN_W-1:0]   bit_q;
  logic [SPAN_W-1:0]   cur_span;
  logic                first_ok, next_ok, slot_end;
  logic [SLOT_W-1:0]   first_idx, next_idx;

  always_comb begin
    first_ok  = 1'b0;
    first_idx = '0;
    next_ok   = 1'b0;
    next_idx  = '0;
    cur_span  = '0;
    for (int j = NSLOT - 1; j >= 0; j--) begin
      if (spans[j*SPAN_W +: SPAN_W] != '0) begin
        first_ok  = 1'b1;
        first_idx = SLOT_W'(j);
        if (SLOT_W'(j) > slot_q) begin
          next_ok  = 1'b1;
          next_idx = SLOT_W'(j);
        end
      end
      if (slot_q == SLOT_W'(j)) cur_span = spans[j*SPAN_W +: SPAN_W];
    end
  end

  assign slot_end   = (bit_q == cur_span - SPAN_W'(1));
  assign load       = (state_q == SQ_IDLE) && strobe;
  assign busy       = (state_q != SQ_IDLE);
  assign cell_valid = (state_q == SQ_RUN);
  assign slot_idx   = slot_q;
  assign bit_pos    = bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      dly_q   <= '0;
      slot_q  <= '0;
      bit_q   <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: if (strobe) begin
          state_q <= SQ_WAIT;
          dly_q   <= delay_in;
        end
        SQ_WAIT: if (dly_q != '0) begin
          dly_q <= dly_q - DELAY_W'(1);
        end else if (first_ok) begin
          state_q <= SQ_RUN;
          slot_q  <= first_idx;
          bit_q   <= '0;
        end else begin
          state_q <= SQ_IDLE;
        end
        SQ_RUN: if (!slot_end) begin
          bit_q <= bit_q + SPAN_W'(1);
        end else if (next_ok) begin
          slot_q <= next_idx;
          bit_q  <= '0;
        end else begin
          state_q <= SQ_IDLE;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  p_delay_countdown_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_WAIT && dly_q != '0) |=> (dly_q == $past(dly_q) - DELAY_W'(1)));

  p_bit_in_span_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_RUN) |-> (bit_q < cur_span));

  p_slot_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_RUN && $past(state_q) == SQ_RUN) |-> (slot_q >= $past(slot_q)));
endmodule

// File: rtl/ssf_cell_mux.sv
module ssf_cell_mux
  import ssf_pkg::*;
#(
  parameter  int NSLOT  = 7,
  parameter  int NSRC   = 7,
  parameter  int WORD_W = 24,
  localparam int SLOT_W = $clog2(NSLOT),
  localparam int SEL_W  = $clog2(NSRC + 1)
) (
  input  logic [NSRC*WORD_W-1:0]      words,
  input  logic [NSLOT*SEL_W-1:0]      sel_codes,
  input  logic [NSLOT*LEN_CODE_W-1:0] len_codes,
  input  logic [NSLOT-1:0]            sync_en,
  input  logic [PLACE_W-1:0]          place,
  input  logic                        cell_valid,
  input  logic [SLOT_W-1:0]           slot_idx,
  input  logic [SPAN_W-1:0]           bit_pos,
  output logic                        c_bit,
  output logic                        sy_before,
  output logic                        sy_align,
  output logic                        sy_after
);
  logic [SEL_W-1:0]      cur_sel;
  logic [LEN_CODE_W-1:0] cur_len;
  logic                  cur_sync;
  logic [WORD_W-1:0]     cur_word, shifted;
  logic [SPAN_W-1:0]     nbits;
  logic                  live, is_first, is_last;

  always_comb begin
    cur_sel  = '0;
    cur_len  = '0;
    cur_sync = 1'b0;
    for (int k = 0; k < NSLOT; k++) begin
      if (slot_idx == SLOT_W'(k)) begin
        cur_sel  = sel_codes[k*SEL_W +: SEL_W];
        cur_len  = len_codes[k*LEN_CODE_W +: LEN_CODE_W];
        cur_sync = sync_en[k];
      end
    end
    cur_word = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (cur_sel == SEL_W'(s)) cur_word = words[s*WORD_W +: WORD_W];
    end
  end

  assign nbits    = len_bits(cur_len);
  assign live     = cell_valid && (nbits != '0);
  // Shifting past the word width yields zero, which also pads 32-bit slots.
  assign shifted  = cur_word << bit_pos;
  assign c_bit    = live && shifted[WORD_W-1];
  assign is_first = live && (bit_pos == '0);
  assign is_last  = live && (bit_pos == nbits - SPAN_W'(1));

  assign sy_before = is_first && cur_sync && (place == PLACE_BEFORE);
  assign sy_align  = is_first && cur_sync && (place == PLACE_ALIGN);
  assign sy_after  = is_last  && cur_sync && (place == PLACE_AFTER);
endmodule

// File: rtl/ssf_sync_shaper.sv
module ssf_sync_shaper (
  input  logic clk,
  input  logic rst_n,
  input  logic c_valid,
  input  logic c_bit,
  input  logic sy_before,
  input  logic sy_align,
  input  logic sy_after,
  input  logic invert,
  output logic sdata,
  output logic sync
);
  logic r_bit, r_align, r_after, t_after;
  logic o_bit, o_act;
  logic sync_act;

  // One lead stage lets the "before" marker precede its data bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_bit   <= 1'b0;
      r_align <= 1'b0;
      r_after <= 1'b0;
      t_after <= 1'b0;
      o_bit   <= 1'b0;
      o_act   <= 1'b0;
    end else begin
      r_bit   <= c_bit;
      r_align <= sy_align;
      r_after <= sy_after;
      t_after <= r_after;
      o_bit   <= r_bit;
      o_act   <= sy_before | r_align | t_after;
    end
  end

  assign sync_act = o_act;
  assign sdata    = o_bit;
  assign sync     = sync_act ^ invert;

  p_quiet_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(c_valid, 2) |-> !sdata);

  p_sync_near_cell_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_act |-> ($past(c_valid) || $past(c_valid, 2) || $past(c_valid, 3)));
endmodule

// File: rtl/slot_serializer.sv
module slot_serializer
  import ssf_pkg::*;
#(
  parameter  int NSLOT   = 7,
  parameter  int NSRC    = 7,
  parameter  int WORD_W  = 24,
  parameter  int DELAY_W = 12,
  localparam int SLOT_W  = $clog2(NSLOT),
  localparam int SEL_W   = $clog2(NSRC + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        strobe,
  input  logic [NSRC*WORD_W-1:0]      src_words,
  input  logic [NSLOT*SEL_W-1:0]      slot_content,
  input  logic [NSLOT*LEN_CODE_W-1:0] slot_length,
  input  logic [NSLOT-1:0]            slot_sync_en,
  input  logic [PLACE_W-1:0]          sync_place,
  input  logic                        sync_invert,
  input  logic [DELAY_W-1:0]          start_delay,
  output logic                        sdata,
  output logic                        sync
);
  logic [NSRC*WORD_W-1:0]      lat_words;
  logic [NSLOT*SEL_W-1:0]      lat_sel;
  logic [NSLOT*LEN_CODE_W-1:0] lat_len;
  logic [NSLOT-1:0]            lat_syen;
  logic [PLACE_W-1:0]          lat_place;
  logic                        lat_inv;

  logic                    load, busy, cell_valid;
  logic [SLOT_W-1:0]       slot_idx;
  logic [SPAN_W-1:0]       bit_pos;
  logic [NSLOT*SPAN_W-1:0] spans;
  logic [NSLOT-1:0]        active;
  logic                    c_bit, sy_before, sy_align, sy_after;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_words <= '0;
      lat_sel   <= '0;
      lat_len   <= '0;
      lat_syen  <= '0;
      lat_place <= '0;
      lat_inv   <= 1'b0;
    end else if (load) begin
      lat_words <= src_words;
      lat_sel   <= slot_content;
      lat_len   <= slot_length;
      lat_syen  <= slot_sync_en;
      lat_place <= sync_place;
      lat_inv   <= sync_invert;
    end
  end

  ssf_slot_plan #(.NSLOT(NSLOT)) u_plan (
    .len_codes (lat_len),
    .spans     (spans),
    .active    (active)
  );

  ssf_frame_seq #(.NSLOT(NSLOT), .DELAY_W(DELAY_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .delay_in   (start_delay),
    .spans      (spans),
    .load       (load),
    .busy       (busy),
    .cell_valid (cell_valid),
    .slot_idx   (slot_idx),
    .bit_pos    (bit_pos)
  );

  ssf_cell_mux #(.NSLOT(NSLOT), .NSRC(NSRC), .WORD_W(WORD_W)) u_mux (
    .words      (lat_words),
    .sel_codes  (lat_sel),
    .len_codes  (lat_len),
    .sync_en    (lat_syen & active),
    .place      (lat_place),
    .cell_valid (cell_valid),
    .slot_idx   (slot_idx),
    .bit_pos    (bit_pos),
    .c_bit      (c_bit),
    .sy_before  (sy_before),
    .sy_align   (sy_align),
    .sy_after   (sy_after)
  );

  ssf_sync_shaper u_shape (
    .clk       (clk),
    .rst_n     (rst_n),
    .c_valid   (cell_valid),
    .c_bit     (c_bit),
    .sy_before (sy_before),
    .sy_align  (sy_align),
    .sy_after  (sy_after),
    .invert    (lat_inv),
    .sdata     (sdata),
    .sync      (sync)
  );

  p_capture_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(lat_words) && $stable(lat_sel) &&
                               $stable(lat_len) && $stable(lat_syen)));
endmodule

// File: tb/tb_slot_serializer.sv
module tb_slot_serializer;
  localparam int NS = 7;
  localparam int WW = 24;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               strobe = 1'b0;
  logic [NS*WW-1:0]   words = '0;
  logic [NS*3-1:0]    csel = '0;
  logic [NS*4-1:0]    clen = '0;
  logic [NS-1:0]      syen = '0;
  logic [1:0]         place = 2'd3;
  logic               inv = 1'b0;
  logic [11:0]        dly = '0;
  logic               sdata, sync;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] seed = 32'h1234_5678;
  logic expd [0:299];
  logic exps [0:299];
  string dtag = "R2";
  string stag = "R9";

  always #2 clk = ~clk;

  slot_serializer dut (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .src_words(words),
    .slot_content(csel), .slot_length(clen), .slot_sync_en(syen),
    .sync_place(place), .sync_invert(inv), .start_delay(dly),
    .sdata(sdata), .sync(sync)
  );

  function automatic int blen(input int c);
    if (c >= 1 && c <= 5) return 2 * c + 2;
    if (c >= 6 && c <= 8) return 4 * c - 8;
    if (c == 9) return 32;
    return 0;
  endfunction

  task automatic rnd(output logic [31:0] v);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    v = seed;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp, input int t);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0d actual=%b expected=%b", tag, t, act, exp);
    end
  endtask

  task automatic build(output int ncell);
    int k;
    k = 0;
    for (int i = 0; i < 300; i++) begin expd[i] = 1'b0; exps[i] = 1'b0; end
    for (int s = 0; s < NS; s++) begin
      int L;
      bit later;
      logic [WW-1:0] w;
      L = blen(int'(clen[s*4 +: 4]));
      later = 0;
      for (int q = s + 1; q < NS; q++) if (blen(int'(clen[q*4 +: 4])) > 0) later = 1;
      w = (int'(csel[s*3 +: 3]) < NS) ? words[int'(csel[s*3 +: 3])*WW +: WW] : '0;
      if (L > 0) begin
        for (int b = 0; b < L; b++) expd[3 + k + b] = (b < WW) ? w[WW-1-b] : 1'b0;
        if (syen[s]) begin
          if (place == 2'd0) exps[2 + k] = 1'b1;
          if (place == 2'd1) exps[3 + k] = 1'b1;
          if (place == 2'd2) exps[4 + k + L - 1] = 1'b1;
        end
        k += L;
      end else if (later) begin
        k += 1;
      end
    end
    ncell = k;
  endtask

  // disturb: 1 = extra strobe mid-frame (R12), 2 = config change mid-frame (R13)
  task automatic run_frame(input int disturb);
    int nc, d, u;
    logic [31:0] r;
    build(nc);
    d = int'(dly);
    @(negedge clk) strobe = 1'b1;
    @(negedge clk) strobe = 1'b0;
    for (int t = 0; t <= d + nc + 7; t++) begin
      u = t - d;
      if (u >= 0 && u < 300) begin
        chk((u >= 3 && u < 3 + nc) ? dtag : "R11", sdata, expd[u], t);
        chk(stag, sync, exps[u] ^ inv, t);
      end else begin
        chk("R11", sdata, 1'b0, t);
        chk("R11", sync, inv, t);
      end
      if (disturb != 0 && t == d + 3 && nc >= 4) begin
        rnd(r);
        words = {r[23:0], words[NS*WW-1:24]} ^ {NS{r[31:8]}};
        clen = ~clen;
        csel = csel ^ 21'h15a5a;
        if (disturb == 1) strobe = 1'b1;
      end
      @(negedge clk) strobe = 1'b0;
    end
  endtask

  task automatic rand_words();
    logic [31:0] r;
    for (int s = 0; s < NS; s++) begin rnd(r); words[s*WW +: WW] = r[WW-1:0]; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    chk("R1", sdata, 1'b0, 0);
    chk("R1", sync, 1'b0, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", sdata, 1'b0, 1);
    chk("R1", sync, 1'b0, 1);

    // R4 R5 R7: every length code on slot 0, sync aligned
    place = 2'd1; syen = 7'h01;
    for (int c = 0; c < 16; c++) begin
      rand_words(); csel = '0; clen = '0; clen[3:0] = 4'(c);
      dtag = (c == 9) ? "R5" : ((c >= 1 && c <= 7) ? "R7" : "R4");
      stag = "R9";
      run_frame(0);
    end

    // R3: every content code, spread over slots, 24-bit length
    for (int c = 0; c < 8; c++) begin
      rand_words(); csel = '0; clen = '0;
      csel[(c % NS)*3 +: 3] = 3'(c); clen[(c % NS)*4 +: 4] = 4'd8;
      dtag = "R3";
      run_frame(0);
    end

    // R2 R6: random slot mixes with disabled slots
    for (int f = 0; f < 40; f++) begin
      rand_words();
      for (int s = 0; s < NS; s++) begin
        rnd(r);
        clen[s*4 +: 4] = (r[7:6] == 2'd0) ? 4'd0 : r[3:0];
        csel[s*3 +: 3] = r[10:8];
        syen[s] = r[12];
      end
      rnd(r); place = r[1:0]; inv = r[2];
      dtag = (f % 2 == 0) ? "R6" : "R2"; stag = "R9";
      run_frame(0);
    end

    // R9 R10: each placement under both polarities
    for (int p = 0; p < 4; p++) begin
      for (int v = 0; v < 2; v++) begin
        rand_words();
        csel = 21'o6543210;
        clen = {4'd1, 4'd0, 4'd3, 4'd0, 4'd2, 4'd1, 4'd1};
        syen = 7'b1010111; place = 2'(p); inv = 1'(v);
        dtag = "R2"; stag = (v == 1) ? "R10" : "R9";
        run_frame(0);
      end
    end

    // R8: start delay extremes
    inv = 1'b0; place = 2'd0; syen = 7'h7f; stag = "R8"; dtag = "R8";
    for (int i = 0; i < 5; i++) begin
      rand_words(); csel = 21'o0123456; clen = {7{4'd1}};
      dly = (i == 4) ? 12'd4095 : 12'(i * i + i);
      run_frame(0);
    end
    dly = 12'd3;

    // R12 / R13: disturbance while the frame runs
    for (int i = 0; i < 4; i++) begin
      rand_words(); csel = 21'o0123456; clen = {4'd2, 4'd0, 4'd5, 4'd9, 4'd0, 4'd3, 4'd1};
      syen = 7'h2d; place = 2'(i % 3);
      dtag = (i % 2 == 0) ? "R12" : "R13"; stag = dtag;
      run_frame((i % 2) + 1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule